// File: doc/BRIEF.md
# Handheld Link Port Register Block

This block holds the bus-visible registers of a handheld console's communication port, together with its mode/status byte. A byte-wide bus reaches seven offsets. Offset 0 is a read-only mode byte. Offset 1 is a seven-bit parallel port whose bits can be set one at a time as inputs or outputs. Offset 2 holds the per-bit direction mask and an NMI enable. Offsets 3 and 4 are the transmit and receive buffers. Offset 5 is a serial control byte whose low bits are hardware status. Offset 6 is a write-only stereo enable byte that is sent to the audio mixer.

The block contains no serial shifter, NMI logic or mixer. The received byte and the serial status bits come in on input pins. The NMI enable and the stereo byte go out on output pins. Read data is combinational from the current offset. A write takes effect on the rising clock edge at which `busSel` and `busWr` are both high.

Top module: `link_port_regs`

## Requirements
- R1: After reset the reads return 0x80 OR the region bits at offset 0, 0x7F at offset 1, 0xFF at offset 2, 0x00 at offset 3, 0xFF at offset 4 and serStatus in bits 2:0 at offset 5. After reset `stereoByte` is 0xFF, `nmiEn` is 1 and `stereoUpd` is 0.
- R2: A read of offset 0 returns the mode byte with bit 7 forced to 0 while `startHeld` is 1. Writes to offset 0 have no effect.
- R3: A read of offset 1 gives, for each bit 0..6, a 1 where the matching direction bit is 1 (input) and the written data latch bit where it is 0 (output). Bit 7 of the read is latch bit 7.
- R4: Offset 2 is read/write in all eight bits. Bit 7 of it is driven on `nmiEn`.
- R5: Offset 3 is read/write and returns the last byte written to it.
- R6: Offset 4 loads `rxByte` on a cycle with `rxLoad` high. Bus writes to offset 4 have no effect.
- R7: A write to offset 5 stores only bits 7:3. Reads of offset 5 return those stored bits with `serStatus` in bits 2:0.
- R8: A write to offset 6 updates `stereoByte` on the next cycle, and `stereoUpd` is high for exactly that one cycle. Reads of offset 6 and of any higher offset return 0xFF.
- R9: When `busSel` is low, no register changes, even if `busWr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access valid |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register offset |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Combinational read data |
| startHeld | input | 1 | Start button held |
| serStatus | input | STAT_W | Serial status bits from the shifter |
| rxLoad | input | 1 | Load strobe for the received byte |
| rxByte | input | DATA_W | Received byte |
| stereoByte | output | DATA_W | Stereo enable byte to the mixer |
| stereoUpd | output | 1 | One-cycle pulse on a new stereo byte |
| nmiEn | output | 1 | NMI enable (direction register bit 7) |

## Verification
The bench uses the default parameters: an 8-bit data bus, a 3-bit offset and 3 status bits. With a 3-bit offset, offset 7 exists on the bus, so the 0xFF return for offsets past the stereo byte is exercised. The region default is 0x40, which makes the mode reset value 0xC0. With bit 6 set, a start press that cleared the wrong bit would show up in the read. Random direction masks against random latch values cover every per-bit mix of input and output on the parallel port.

// File: rtl/link_port_pkg.sv
package link_port_pkg;

  typedef enum logic [2:0] {
    SEL_MODE   = 3'd0,
    SEL_PAR    = 3'd1,
    SEL_DIR    = 3'd2,
    SEL_TX     = 3'd3,
    SEL_RX     = 3'd4,
    SEL_SER    = 3'd5,
    SEL_STEREO = 3'd6,
    SEL_NONE   = 3'd7
  } rdSel_e;

  typedef struct packed {
    logic   wrPar;
    logic   wrDir;
    logic   wrTx;
    logic   wrSer;
    logic   wrStereo;
    rdSel_e rdSel;
  } ctrlStrb_t;

endpackage

// File: rtl/link_port_ctrl.sv
module link_port_ctrl
  import link_port_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrb_t         strb
);
  localparam logic [ADDR_W-1:0] OFS_PAR    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_DIR    = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_TX     = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFS_SER    = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] OFS_STEREO = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] OFS_LAST   = ADDR_W'(7);

  logic wrAcc;
  assign wrAcc = busSel & busWr;

  always_comb begin
    strb          = '0;
    strb.wrPar    = wrAcc && (busAddr == OFS_PAR);
    strb.wrDir    = wrAcc && (busAddr == OFS_DIR);
    strb.wrTx     = wrAcc && (busAddr == OFS_TX);
    strb.wrSer    = wrAcc && (busAddr == OFS_SER);
    strb.wrStereo = wrAcc && (busAddr == OFS_STEREO);
    if (busAddr > OFS_LAST) strb.rdSel = SEL_NONE;
    else                    strb.rdSel = rdSel_e'(busAddr[2:0]);
  end
endmodule

// File: rtl/link_port_dp.sv
module link_port_dp
  import link_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STAT_W = 3,
  parameter logic [DATA_W-2:0] REGION_BITS = 'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              startHeld,
  input  logic [STAT_W-1:0] serStatus,
  input  logic              rxLoad,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] stereoByte,
  output logic              stereoUpd,
  output logic              nmiEn
);
  localparam int PAR_W    = DATA_W - 1;
  localparam int SER_KEEP = DATA_W - STAT_W;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] MODE_RST = {1'b1, REGION_BITS};

  logic [DATA_W-1:0]   parLatch, dirReg, txReg, rxReg, stereoReg;
  logic [SER_KEEP-1:0] serKeep;
  logic                updQ;
  logic [DATA_W-1:0]   parView, modeView, serView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           parLatch <= '0;
    else if (strb.wrPar) parLatch <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           dirReg <= ALL_ONES;
    else if (strb.wrDir) dirReg <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          txReg <= '0;
    else if (strb.wrTx) txReg <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       rxReg <= ALL_ONES;
    else if (rxLoad) rxReg <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           serKeep <= '0;
    else if (strb.wrSer) serKeep <= wdata[DATA_W-1:STAT_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stereoReg <= ALL_ONES;
      updQ      <= 1'b0;
    end else begin
      updQ <= strb.wrStereo;
      if (strb.wrStereo) stereoReg <= wdata;
    end
  end

  // unconnected parallel pins read high when set as inputs
  for (genvar i = 0; i < PAR_W; i++) begin : g_parBit
    assign parView[i] = dirReg[i] ? 1'b1 : parLatch[i];
  end
  assign parView[DATA_W-1] = parLatch[DATA_W-1];

  assign modeView = {MODE_RST[DATA_W-1] & ~startHeld, MODE_RST[DATA_W-2:0]};
  assign serView  = {serKeep, serStatus};

  always_comb begin
    unique case (strb.rdSel)
      SEL_MODE: rdata = modeView;
      SEL_PAR:  rdata = parView;
      SEL_DIR:  rdata = dirReg;
      SEL_TX:   rdata = txReg;
      SEL_RX:   rdata = rxReg;
      SEL_SER:  rdata = serView;
      default:  rdata = ALL_ONES;
    endcase
  end

  assign stereoByte = stereoReg;
  assign stereoUpd  = updQ;
  assign nmiEn      = dirReg[DATA_W-1];
endmodule

// File: rtl/link_port_regs.sv
module link_port_regs
  import link_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int STAT_W = 3,
  parameter logic [DATA_W-2:0] REGION_BITS = 'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              startHeld,
  input  logic [STAT_W-1:0] serStatus,
  input  logic              rxLoad,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] stereoByte,
  output logic              stereoUpd,
  output logic              nmiEn
);
  ctrlStrb_t strb;

  link_port_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb)
  );

  link_port_dp #(
    .DATA_W     (DATA_W),
    .STAT_W     (STAT_W),
    .REGION_BITS(REGION_BITS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wdata     (busWdata),
    .startHeld (startHeld),
    .serStatus (serStatus),
    .rxLoad    (rxLoad),
    .rxByte    (rxByte),
    .rdata     (busRdata),
    .stereoByte(stereoByte),
    .stereoUpd (stereoUpd),
    .nmiEn     (nmiEn)
  );
endmodule

// File: rtl/link_port_regs_chk.sv
module link_port_regs_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int STAT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              startHeld,
  input logic [STAT_W-1:0] serStatus,
  input logic              rxLoad,
  input logic [DATA_W-1:0] rxByte,
  input logic [DATA_W-1:0] stereoByte,
  input logic              stereoUpd,
  input logic              nmiEn
);
  p_mode_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(0) && startHeld) |-> !busRdata[DATA_W-1]);

  p_nmi_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr && busAddr == ADDR_W'(2)) |=> $stable(nmiEn));

  p_ser_status_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(5)) |-> busRdata[STAT_W-1:0] == serStatus);

  p_stereo_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_W'(6)) |=> stereoUpd && stereoByte == $past(busWdata));

  p_stereo_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr && busAddr == ADDR_W'(6)) |=> !stereoUpd && $stable(stereoByte));

  p_high_ofs_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= ADDR_W'(6)) |-> busRdata == {DATA_W{1'b1}});

  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(4) && !rxLoad) |=> (busAddr != ADDR_W'(4)) || $stable(busRdata));
endmodule

bind link_port_regs link_port_regs_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .STAT_W(STAT_W)
) chk_i (.*);

// File: tb/link_port_regs_tb_top.sv
`timescale 1ns/1ps
module link_port_regs_tb_top;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int STAT_W = 3;
  localparam int REGION = 'h40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic startHeld = 1'b0;
  logic [STAT_W-1:0] serStatus = '0;
  logic rxLoad = 1'b0;
  logic [DATA_W-1:0] rxByte = '0;
  logic [DATA_W-1:0] stereoByte;
  logic stereoUpd, nmiEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  link_port_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_W(STAT_W),
                   .REGION_BITS(7'(REGION))) dut_i (.*);

  // behavioural reference model
  int mPar, mDir, mTx, mRx, mSer, mSt, mUpd;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPar <= 0; mDir <= 255; mTx <= 0; mRx <= 255; mSer <= 0; mSt <= 255; mUpd <= 0;
    end else begin
      mUpd <= (busSel && busWr && busAddr == 6) ? 1 : 0;
      if (rxLoad) mRx <= rxByte;
      if (busSel && busWr) begin
        if (busAddr == 1) mPar <= busWdata;
        if (busAddr == 2) mDir <= busWdata;
        if (busAddr == 3) mTx  <= busWdata;
        if (busAddr == 5) mSer <= busWdata & 'hF8;
        if (busAddr == 6) mSt  <= busWdata;
      end
    end
  end

  function automatic int expRead(int a);
    case (a)
      0: return startHeld ? (REGION & 'h7F) : ('h80 | REGION);
      1: return (mPar & ~(mDir & 'h7F) & 'hFF) | (mDir & 'h7F);
      2: return mDir;
      3: return mTx;
      4: return mRx;
      5: return mSer | serStatus;
      default: return 'hFF;
    endcase
  endfunction

  function automatic string reqOf(int a);
    case (a)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, sampled just before the rising edge
  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      check(reqOf(busAddr), busRdata, expRead(busAddr));
      check("R8 upd", stereoUpd, mUpd);
      check("R8 byte", stereoByte, mSt);
      check("R4 nmi", nmiEn, (mDir >> 7) & 1);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = ADDR_W'(a); busWdata = DATA_W'(d);
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic rd(int a, int exp, string tag);
    busAddr = ADDR_W'(a); busSel = 1; busWr = 0;
    #1;
    check(tag, busRdata, exp);
    busSel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, 'hC0, "R1 mode"); rd(1, 'h7F, "R1 par"); rd(2, 'hFF, "R1 dir");
    rd(3, 'h00, "R1 tx");   rd(4, 'hFF, "R1 rx");  rd(5, 'h00, "R1 ser");
    check("R1 stereo", stereoByte, 'hFF); check("R1 nmi", nmiEn, 1);
    check("R1 upd", stereoUpd, 0);
    // R2 start button, writes ignored
    startHeld = 1; rd(0, 'h40, "R2 start"); startHeld = 0;
    wr(0, 'h00); rd(0, 'hC0, "R2 wr ignored");
    // R3 parallel mixing
    wr(2, 'h0F); wr(1, 'hA5); rd(1, 'hAF, "R3 mixed");
    wr(2, 'h00); rd(1, 'hA5, "R3 all out");
    wr(2, 'h7F); wr(1, 'h5A); rd(1, 'h7F, "R3 all in");
    // R4 direction / nmi
    wr(2, 'h80); rd(2, 'h80, "R4 dir"); check("R4 nmi on", nmiEn, 1);
    wr(2, 'h00); check("R4 nmi off", nmiEn, 0);
    // R5 tx
    wr(3, 'h3C); rd(3, 'h3C, "R5 tx");
    // R6 rx
    @(negedge clk); rxLoad = 1; rxByte = 'h96; @(negedge clk); rxLoad = 0;
    rd(4, 'h96, "R6 load"); wr(4, 'h11); rd(4, 'h96, "R6 wr ignored");
    // R7 serial control
    serStatus = 3'b101; wr(5, 'hFF); rd(5, 'hFD, "R7 keep hi");
    wr(5, 'h07); rd(5, 'h05, "R7 low ro");
    // R8 stereo
    wr(6, 'h33);
    check("R8 pulse", stereoUpd, 1); check("R8 byte", stereoByte, 'h33);
    @(negedge clk); check("R8 one cycle", stereoUpd, 0);
    rd(6, 'hFF, "R8 rd6"); rd(7, 'hFF, "R8 rd7");
    // R9 write without select
    @(negedge clk); busSel = 0; busWr = 1; busAddr = 3; busWdata = 'hEE;
    @(negedge clk); busWr = 0; rd(3, 'h3C, "R9 no sel");
    // random traffic, checked every cycle against the model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      busSel = 1'($urandom); busWr = 1'($urandom);
      busAddr = ADDR_W'($urandom); busWdata = DATA_W'($urandom);
      startHeld = 1'($urandom); serStatus = STAT_W'($urandom);
      rxLoad = ($urandom % 4) == 0; rxByte = DATA_W'($urandom);
    end
    @(negedge clk); busSel = 0; busWr = 0; rxLoad = 0;
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule